// File: doc/BRIEF.md
# Flash Read Wait-State Controller

This block sits in the read path between a CPU and a slow non-volatile memory array. The array is treated as an asynchronous read port whose data settles within a fixed time. When the system clock runs faster than the array can follow, the controller holds each CPU read off for one extra cycle. Software can turn that wait-state off once the clock has been lowered, so reads finish in the cycle they are issued.

A change to the wait-state setting does not take effect as soon as it is written. The new value waits until no array read is in flight. A read that is already running finishes with the setting it started with. A status bit lets software poll until the new value is in force.

The same register port holds a clock divider value for the array's timing logic. Software rewrites the divider after every change of system frequency. A lock bit can freeze the divider, and once set it stays set until reset.

Top module: `flash_ws_ctrl`

## Requirements
- R1: After reset, the configuration register (address 0, wait-state field in bits [1:0]) reads 2'b11, the status register (address 1) reads 1 in bit 0, and the divider register (address 2) reads 8'h00.
- R2: While the applied wait-state field is nonzero, a read with `cpu_valid_i` held high sees `cpu_ready_o` low in its first cycle and high in its second, which is exactly one wait-state.
- R3: While the applied wait-state field is 2'b00, `cpu_ready_o` is high in the same cycle that `cpu_valid_i` is raised, with no wait-state.
- R4: From the cycle after a write to the wait-state field, status bit 0 reads 0 until the written value is applied, and then it reads 1. The configuration register reads back the written value at once.
- R5: A written wait-state value is applied on the first clock edge at which no read is in its wait cycle. A read already in its wait cycle completes with the old value.
- R6: `arr_addr_o` follows `cpu_addr_i`, and in the cycle where `cpu_ready_o` is high, `cpu_rdata_o` equals `arr_rdata_i`.
- R7: While unlocked, a write to address 2 loads the divider value from bits [6:0] and the lock from bit 7. The register reads back as {lock, divider}, and `div_o` shows the divider value.
- R8: Once the lock bit is set, every write to address 2 is ignored and the register and `div_o` keep their values. Only reset clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | CPU read request, held until ready |
| cpu_addr_i | input | ADDR_W | CPU read address |
| cpu_ready_o | output | 1 | Read completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid when ready |
| arr_addr_o | output | ADDR_W | Array read address |
| arr_rdata_i | input | DATA_W | Array read data |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | DIV_W+1 | Register write data |
| reg_rdata_o | output | DIV_W+1 | Register read data (combinational) |
| div_o | output | DIV_W | Clock divider value |

## Verification
The assertions assume that the CPU holds `cpu_valid_i` and `cpu_addr_i` steady from the moment it raises a request until the cycle in which `cpu_ready_o` is high. The stall check depends on this: a ready with wait-states enabled must follow a cycle in which the request was already present. The bench driver keeps every request asserted until it sees ready and drops it only after that edge. It issues register writes as single-cycle pulses between clock edges, and these can overlap a read. The safe-point and acknowledge checks therefore see both the idle case and the busy case.

// File: rtl/flash_ws_pkg.sv
package flash_ws_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned WS_W   = 2;

  localparam logic [REG_AW-1:0] ADDR_CFG  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_DIV  = 2'd2;

  localparam logic [WS_W-1:0] WS_RESET = '1;

  typedef enum logic {
    RD_IDLE,
    RD_WAIT
  } rd_state_e;
endpackage

// File: rtl/flash_ws_regs.sv
module flash_ws_regs
  import flash_ws_pkg::*;
#(
  parameter int unsigned DIV_W = 7,
  localparam int unsigned REG_DW = DIV_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_AW-1:0]     reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [REG_DW-1:0]     reg_wdata_i,
  output logic [REG_DW-1:0]     reg_rdata_o,
  input  logic                  rd_busy_i,
  output logic [WS_W-1:0]       ws_eff_o,
  output logic [DIV_W-1:0]      div_o
);
  logic [WS_W-1:0]  ws_req_q, ws_eff_q;
  logic             pend_q;
  logic [DIV_W-1:0] div_q;
  logic             lock_q;
  logic             cfg_we, div_we, ack;

  assign cfg_we = reg_we_i && (reg_addr_i == ADDR_CFG);
  assign div_we = reg_we_i && (reg_addr_i == ADDR_DIV);
  assign ack    = !pend_q;

  // new setting waits for a read-free edge; a fresh write restarts the wait
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_req_q <= WS_RESET;
      ws_eff_q <= WS_RESET;
      pend_q   <= 1'b0;
    end else if (cfg_we) begin
      ws_req_q <= reg_wdata_i[WS_W-1:0];
      pend_q   <= 1'b1;
    end else if (pend_q && !rd_busy_i) begin
      ws_eff_q <= ws_req_q;
      pend_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      lock_q <= 1'b0;
    end else if (div_we && !lock_q) begin
      div_q  <= reg_wdata_i[DIV_W-1:0];
      lock_q <= reg_wdata_i[DIV_W];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_CFG:  reg_rdata_o[WS_W-1:0] = ws_req_q;
      ADDR_STAT: reg_rdata_o[0]        = ack;
      ADDR_DIV:  reg_rdata_o           = {lock_q, div_q};
      default:   reg_rdata_o           = '0;
    endcase
  end

  assign ws_eff_o = ws_eff_q;
  assign div_o    = div_q;

  assert_ack_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we |=> !ack);
  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  assert_div_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(div_q));
endmodule

// File: rtl/flash_ws_rd.sv
module flash_ws_rd
  import flash_ws_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic ws_on_i,
  output logic ready_o,
  output logic busy_o
);
  rd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RD_IDLE: if (valid_i && ws_on_i) state_d = RD_WAIT;
      RD_WAIT: state_d = RD_IDLE;
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RD_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o = (state_q == RD_WAIT) || (valid_i && !ws_on_i);
  assign busy_o  = (state_q == RD_WAIT);

  assert_wait_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RD_WAIT) |=> (state_q == RD_IDLE));
  assert_ws_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && ws_on_i) |-> $past(valid_i));
endmodule

// File: rtl/flash_ws_ctrl.sv
module flash_ws_ctrl
  import flash_ws_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DIV_W:0]    reg_wdata_i,
  output logic [DIV_W:0]    reg_rdata_o,
  output logic [DIV_W-1:0]  div_o
);
  logic [WS_W-1:0] ws_eff;
  logic            rd_busy;

  flash_ws_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_addr_i (reg_addr_i),
    .reg_we_i   (reg_we_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .rd_busy_i  (rd_busy),
    .ws_eff_o   (ws_eff),
    .div_o      (div_o)
  );

  flash_ws_rd u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(cpu_valid_i),
    .ws_on_i(|ws_eff),
    .ready_o(cpu_ready_o),
    .busy_o (rd_busy)
  );

  assign arr_addr_o  = cpu_addr_i;
  assign cpu_rdata_o = cpu_ready_o ? arr_rdata_i : '0;

  assert_safe_apply_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws_eff != $past(ws_eff)) |-> !$past(rd_busy));
endmodule

// File: tb/flash_ws_ctrl_test.sv
module flash_ws_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 7;

  typedef struct {
    logic [DATA_W-1:0] data;
    int                waits;
    string             req;
  } exp_t;

  logic              clk = 0, rst_n = 0;
  logic              valid = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ready;
  logic [DATA_W-1:0] rdata, arr_data;
  logic [ADDR_W-1:0] arr_addr;
  logic [1:0]        raddr = '0;
  logic              we = 0;
  logic [DIV_W:0]    wdata = '0, rdreg;
  logic [DIV_W-1:0]  div;

  int checks = 0, errors = 0, stall_cnt = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] arr_model(logic [ADDR_W-1:0] a);
    return {~a, a};
  endfunction
  assign arr_data = arr_model(arr_addr);

  flash_ws_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(valid), .cpu_addr_i(addr), .cpu_ready_o(ready), .cpu_rdata_o(rdata),
    .arr_addr_o(arr_addr), .arr_rdata_i(arr_data),
    .reg_addr_i(raddr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdreg),
    .div_o(div)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: counts stall cycles and pops the scoreboard on each completion
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (!ready) stall_cnt++;
      else begin
        exp_t e;
        if (exp_q.size() == 0) check("scoreboard", 1, 0);
        else begin
          e = exp_q.pop_front();
          check({e.req, " data R6"}, rdata, e.data);
          check({e.req, " waits"}, stall_cnt, e.waits);
          check("R6 arr_addr", arr_addr, addr);
        end
        stall_cnt = 0;
      end
    end
  end

  task automatic cpu_read(logic [ADDR_W-1:0] a, int waits, string req);
    exp_t e;
    e.data = arr_model(a); e.waits = waits; e.req = req;
    exp_q.push_back(e);
    @(posedge clk); #1;
    valid = 1; addr = a;
    forever begin
      @(negedge clk);
      if (ready) break;
    end
    @(posedge clk); #1;
    valid = 0;
  endtask

  task automatic reg_write(logic [1:0] a, logic [DIV_W:0] d);
    @(posedge clk); #1;
    raddr = a; wdata = d; we = 1;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic reg_check(logic [1:0] a, logic [DIV_W:0] exp, string req);
    raddr = a; #1;
    check(req, rdreg, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1) rst_n = 1;
    reg_check(0, 8'h03, "R1 cfg reset");
    reg_check(1, 8'h01, "R1 ack reset");
    reg_check(2, 8'h00, "R1 div reset");

    // reset setting: one wait per read, back to back
    cpu_read(16'h1234, 1, "R2");
    cpu_read(16'hBEEF, 1, "R2");

    // disable wait-states while idle
    reg_write(0, 8'h00);
    reg_check(1, 8'h00, "R4 ack low after write");
    reg_check(0, 8'h00, "R4 cfg readback");
    @(posedge clk); #1;
    reg_check(1, 8'h01, "R4 ack high once applied");
    cpu_read(16'h0001, 0, "R3");
    cpu_read(16'hFFFF, 0, "R3");

    // nonzero non-max value still one wait
    reg_write(0, 8'h02);
    @(posedge clk); #1;
    reg_check(1, 8'h01, "R4 ack after 2");
    cpu_read(16'h5A5A, 1, "R2 ws=2");

    // write landing on the edge a read enters its wait cycle
    fork
      cpu_read(16'h0F0F, 1, "R5 old setting");
      begin
        @(posedge clk); #1;
        raddr = 0; wdata = 8'h00; we = 1;
        @(posedge clk); #1;
        we = 0;
        reg_check(1, 8'h00, "R5 pending while busy");
        @(posedge clk); #1;
        reg_check(1, 8'h00, "R5 pending at completion edge");
        @(posedge clk); #1;
        reg_check(1, 8'h01, "R5 applied when idle");
      end
    join
    cpu_read(16'h7777, 0, "R5 new setting");

    // divider and lock
    reg_write(2, 8'h25);
    reg_check(2, 8'h25, "R7 div write");
    check("R7 div_o", div, 7'h25);
    reg_write(2, 8'h40);
    reg_check(2, 8'h40, "R7 div rewrite");
    reg_write(2, 8'h91);
    reg_check(2, 8'h91, "R8 lock set");
    reg_write(2, 8'h33);
    reg_check(2, 8'h91, "R8 write ignored");
    check("R8 div_o held", div, 7'h11);
    reg_write(2, 8'h00);
    reg_check(2, 8'h91, "R8 unlock ignored");

    @(posedge clk); #1 rst_n = 0;
    #(CLK_PERIOD) rst_n = 1;
    reg_check(2, 8'h00, "R8 reset clears lock");
    reg_check(0, 8'h03, "R1 cfg after reset");
    reg_write(2, 8'h0A);
    reg_check(2, 8'h0A, "R8 writable after reset");
    cpu_read(16'h2468, 1, "R2 after reset");

    repeat (3) @(posedge clk);
    check("scoreboard empty", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule